// File: doc/BRIEF.md
# Compressed-Aware Instruction Realigner

This block sits between the instruction fetch port and the instruction queue of a RISC-V core that supports the compressed extension. Each cycle it may receive one 32-bit fetch block. The block comes with a valid flag and an address whose two low bits are ignored for word selection. The realigner splits the block into halfwords and decides whether each halfword starts a 16-bit or a 32-bit instruction. It presents up to two instructions on two output slots. Each slot has its own valid bit, a 32-bit instruction field and an address.

Sometimes a 32-bit instruction begins in the upper halfword of a block. Its second half then arrives only with the next fetch block. The realigner keeps the leading halfword in a carry register and emits nothing for it. It joins that halfword with the lower halfword of the next valid block, and raises a flag for the cycle in which the joined instruction is presented.

After a redirect, the fetch may enter a word at its upper halfword. In that case the lower halfword of the first block is thrown away. A flush input empties the carry register.

Top module: `rvc_realigner`

## Requirements
- R1: After reset no halfword is held. The first valid block is decoded from its own contents only, with `straddle_o` low.
- R2: A halfword whose bits [1:0] are 00, 01 or 10 is a 16-bit instruction. A halfword whose bits [1:0] are 11 starts a 32-bit instruction. A 16-bit instruction is shown in a slot with bits [31:16] equal to zero.
- R3: With nothing held and a word-entry address, a 32-bit instruction in the lower halfword is emitted whole in slot 0. Its slot address is the block address with bits [1:0] = 00, and slot 1 is invalid.
- R4: With nothing held and a word-entry address, two 16-bit instructions are both emitted. The lower halfword goes to slot 0 at block address +0. The upper halfword goes to slot 1 at block address +2.
- R5: With nothing held, a 16-bit lower halfword followed by a 32-bit start in the upper halfword gives slot 0 only. The upper halfword is held and not emitted.
- R6: When a halfword is held, the next valid block puts {block bits [15:0], held halfword} in slot 0 and raises `straddle_o`. The slot address is the held halfword's address, whose bits [1:0] are 10.
- R7: In a block that completes a held instruction, the upper halfword goes to slot 1 at +2 if it is 16-bit. If it starts a 32-bit instruction, it is held again and nothing is emitted for it.
- R8: With nothing held and address bit 1 set, the lower halfword is dropped. A 16-bit upper halfword goes to slot 0 at +2. A 32-bit start in the upper halfword is held.
- R9: While `flush_i` is high both slots are invalid and any held halfword is discarded. The next block is decoded as in R1.
- R10: While `blk_valid_i` is low both slots are invalid and a held halfword is kept for the next valid block.
- R11: Slot 1 is never valid unless slot 0 is valid in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Discards held state and mutes outputs this cycle |
| blk_valid_i | input | 1 | Fetch block present |
| blk_addr_i | input | ADDR_W | Fetch address; bit 1 marks upper-halfword entry |
| blk_data_i | input | 32 | Fetch block, lower halfword in bits [15:0] |
| slot_valid_o | output | 2 | Per-slot valid, bit 0 for slot 0 |
| slot0_instr_o | output | 32 | First instruction |
| slot1_instr_o | output | 32 | Second instruction |
| slot0_addr_o | output | ADDR_W | Address of first instruction |
| slot1_addr_o | output | ADDR_W | Address of second instruction |
| straddle_o | output | 1 | Slot 0 holds an instruction joined across two blocks |

## Verification
The directed part feeds each halfword combination on its own: an aligned 32-bit word, a compressed pair, and compressed-then-carry. It also feeds a carry completed by a compressed or a 32-bit upper halfword, a chain of carries, and an upper-halfword entry of either kind. Each of these separates one decoding branch from its neighbours. Flush and idle cycles are placed while a halfword is held, which shows whether the carry is dropped or kept. The random run mixes roughly even compressed and 32-bit halfwords with gaps, flushes and odd entries after redirects. This exposes wrong carry addresses and stale state over long sequences.

// File: rtl/rvc_realign_pkg.sv
package rvc_realign_pkg;
   localparam int HALF_W  = 16;
   localparam int INSTR_W = 2 * HALF_W;
   localparam int SLOTS   = 2;

   function automatic logic half_is_rvc(input logic [1:0] low_bits);
      return low_bits != 2'b11;
   endfunction
endpackage

// File: rtl/rlg_half_scan.sv
module rlg_half_scan
   import rvc_realign_pkg::*;
#(
   parameter int W = HALF_W
) (
   input  logic [W-1:0] half_i,
   output logic         is_rvc_o
);
   if (W < 2) begin : g_bad_w
      $error("rlg_half_scan: W must be at least 2");
   end

   assign is_rvc_o = half_is_rvc(half_i[1:0]);
endmodule

// File: rtl/rlg_carry_reg.sv
module rlg_carry_reg
   import rvc_realign_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush_i,
   input  logic              load_i,
   input  logic              nxt_pend_i,
   input  logic [HALF_W-1:0] nxt_half_i,
   input  logic [ADDR_W-1:0] nxt_addr_i,
   output logic              pend_o,
   output logic [HALF_W-1:0] half_o,
   output logic [ADDR_W-1:0] addr_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_o <= 1'b0;
         half_o <= '0;
         addr_o <= '0;
      end else if (flush_i) begin
         pend_o <= 1'b0;
      end else if (load_i) begin
         pend_o <= nxt_pend_i;
         if (nxt_pend_i) begin
            half_o <= nxt_half_i;
            addr_o <= nxt_addr_i;
         end
      end
   end
endmodule

// File: rtl/rlg_extract.sv
module rlg_extract
   import rvc_realign_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic               blk_valid_i,
   input  logic               flush_i,
   input  logic [ADDR_W-1:0]  blk_addr_i,
   input  logic               odd_entry_i,
   input  logic [INSTR_W-1:0] blk_data_i,
   input  logic [SLOTS-1:0]   rvc_i,
   input  logic               pend_i,
   input  logic [HALF_W-1:0]  held_half_i,
   input  logic [ADDR_W-1:0]  held_addr_i,
   output logic [SLOTS-1:0]   slot_vld_o,
   output logic [INSTR_W-1:0] slot0_instr_o,
   output logic [INSTR_W-1:0] slot1_instr_o,
   output logic [ADDR_W-1:0]  slot0_addr_o,
   output logic [ADDR_W-1:0]  slot1_addr_o,
   output logic               straddle_o,
   output logic               load_o,
   output logic               nxt_pend_o,
   output logic [HALF_W-1:0]  nxt_half_o,
   output logic [ADDR_W-1:0]  nxt_addr_o
);
   localparam int PAD_W = INSTR_W - HALF_W;

   logic [ADDR_W-1:0] base_addr, upper_addr;
   logic [HALF_W-1:0] lo_half, hi_half;

   assign base_addr  = {blk_addr_i[ADDR_W-1:2], 2'b00};
   assign upper_addr = {blk_addr_i[ADDR_W-1:2], 2'b10};
   assign lo_half    = blk_data_i[HALF_W-1:0];
   assign hi_half    = blk_data_i[INSTR_W-1:HALF_W];
   assign load_o     = blk_valid_i && !flush_i;

   always_comb begin
      slot_vld_o    = '0;
      slot0_instr_o = '0;
      slot1_instr_o = '0;
      slot0_addr_o  = '0;
      slot1_addr_o  = '0;
      straddle_o    = 1'b0;
      nxt_pend_o    = 1'b0;
      nxt_half_o    = hi_half;
      nxt_addr_o    = upper_addr;
      if (load_o) begin
         if (pend_i) begin
            slot_vld_o[0] = 1'b1;
            slot0_instr_o = {lo_half, held_half_i};
            slot0_addr_o  = held_addr_i;
            straddle_o    = 1'b1;
            if (rvc_i[1]) begin
               slot_vld_o[1] = 1'b1;
               slot1_instr_o = {{PAD_W{1'b0}}, hi_half};
               slot1_addr_o  = upper_addr;
            end else begin
               nxt_pend_o = 1'b1;
            end
         end else if (odd_entry_i) begin
            if (rvc_i[1]) begin
               slot_vld_o[0] = 1'b1;
               slot0_instr_o = {{PAD_W{1'b0}}, hi_half};
               slot0_addr_o  = upper_addr;
            end else begin
               nxt_pend_o = 1'b1;
            end
         end else if (!rvc_i[0]) begin
            slot_vld_o[0] = 1'b1;
            slot0_instr_o = blk_data_i;
            slot0_addr_o  = base_addr;
         end else begin
            slot_vld_o[0] = 1'b1;
            slot0_instr_o = {{PAD_W{1'b0}}, lo_half};
            slot0_addr_o  = base_addr;
            if (rvc_i[1]) begin
               slot_vld_o[1] = 1'b1;
               slot1_instr_o = {{PAD_W{1'b0}}, hi_half};
               slot1_addr_o  = upper_addr;
            end else begin
               nxt_pend_o = 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/rvc_realigner.sv
module rvc_realigner
   import rvc_realign_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter bit ODD_ENTRY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush_i,
   input  logic              blk_valid_i,
   input  logic [ADDR_W-1:0] blk_addr_i,
   input  logic [31:0]       blk_data_i,
   output logic [1:0]        slot_valid_o,
   output logic [31:0]       slot0_instr_o,
   output logic [31:0]       slot1_instr_o,
   output logic [ADDR_W-1:0] slot0_addr_o,
   output logic [ADDR_W-1:0] slot1_addr_o,
   output logic              straddle_o
);
   if (ADDR_W < 3) begin : g_bad_addr
      $error("rvc_realigner: ADDR_W must be at least 3");
   end
   if (INSTR_W != 32 || SLOTS != 2) begin : g_bad_pkg
      $error("rvc_realigner: package widths do not match the port list");
   end

   logic [SLOTS-1:0]  rvc;
   logic              odd_entry;
   logic              pend, load, nxt_pend;
   logic [HALF_W-1:0] held_half, nxt_half;
   logic [ADDR_W-1:0] held_addr, nxt_addr;

   for (genvar h = 0; h < SLOTS; h++) begin : g_scan
      rlg_half_scan #(.W(HALF_W)) u_scan (
         .half_i   (blk_data_i[h*HALF_W +: HALF_W]),
         .is_rvc_o (rvc[h])
      );
   end

   if (ODD_ENTRY) begin : g_odd
      assign odd_entry = blk_addr_i[1];
   end else begin : g_even
      assign odd_entry = 1'b0;
   end

   rlg_extract #(.ADDR_W(ADDR_W)) u_ext (
      .blk_valid_i   (blk_valid_i),
      .flush_i       (flush_i),
      .blk_addr_i    (blk_addr_i),
      .odd_entry_i   (odd_entry),
      .blk_data_i    (blk_data_i),
      .rvc_i         (rvc),
      .pend_i        (pend),
      .held_half_i   (held_half),
      .held_addr_i   (held_addr),
      .slot_vld_o    (slot_valid_o),
      .slot0_instr_o (slot0_instr_o),
      .slot1_instr_o (slot1_instr_o),
      .slot0_addr_o  (slot0_addr_o),
      .slot1_addr_o  (slot1_addr_o),
      .straddle_o    (straddle_o),
      .load_o        (load),
      .nxt_pend_o    (nxt_pend),
      .nxt_half_o    (nxt_half),
      .nxt_addr_o    (nxt_addr)
   );

   rlg_carry_reg #(.ADDR_W(ADDR_W)) u_carry (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush_i    (flush_i),
      .load_i     (load),
      .nxt_pend_i (nxt_pend),
      .nxt_half_i (nxt_half),
      .nxt_addr_i (nxt_addr),
      .pend_o     (pend),
      .half_o     (held_half),
      .addr_o     (held_addr)
   );
endmodule

// File: rtl/rvc_realigner_chk.sv
module rvc_realigner_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              flush_i,
   input logic              blk_valid_i,
   input logic [ADDR_W-1:0] blk_addr_i,
   input logic [1:0]        slot_valid_o,
   input logic [31:0]       slot1_instr_o,
   input logic [ADDR_W-1:0] slot0_addr_o,
   input logic [ADDR_W-1:0] slot1_addr_o,
   input logic              straddle_o
);
   AST_SLOT1_NEEDS_SLOT0: assert property (@(posedge clk) disable iff (!rst_n)
      slot_valid_o[1] |-> slot_valid_o[0]); // R11
   AST_FLUSH_MUTES: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |-> slot_valid_o == 2'b00); // R9
   AST_FLUSH_DROPS_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> !straddle_o); // R9
   AST_IDLE_MUTES: assert property (@(posedge clk) disable iff (!rst_n)
      !blk_valid_i |-> slot_valid_o == 2'b00); // R10
   AST_STRADDLE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
      straddle_o |-> slot_valid_o[0] && slot0_addr_o[1:0] == 2'b10); // R6
   AST_SLOT1_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      slot_valid_o[1] |-> slot1_addr_o == {blk_addr_i[ADDR_W-1:2], 2'b10}); // R4
   AST_SLOT1_RVC_FORM: assert property (@(posedge clk) disable iff (!rst_n)
      slot_valid_o[1] |-> slot1_instr_o[31:16] == 16'h0 && slot1_instr_o[1:0] != 2'b11); // R2
endmodule

bind rvc_realigner rvc_realigner_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .flush_i       (flush_i),
   .blk_valid_i   (blk_valid_i),
   .blk_addr_i    (blk_addr_i),
   .slot_valid_o  (slot_valid_o),
   .slot1_instr_o (slot1_instr_o),
   .slot0_addr_o  (slot0_addr_o),
   .slot1_addr_o  (slot1_addr_o),
   .straddle_o    (straddle_o)
);

// File: tb/sim_rvc_realigner.sv
`timescale 1ns/1ps
module sim_rvc_realigner;
   localparam int AW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          flush_i = 1'b0;
   logic          blk_valid_i = 1'b0;
   logic [AW-1:0] blk_addr_i = '0;
   logic [31:0]   blk_data_i = '0;
   logic [1:0]    slot_valid_o;
   logic [31:0]   slot0_instr_o, slot1_instr_o;
   logic [AW-1:0] slot0_addr_o, slot1_addr_o;
   logic          straddle_o;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   logic          m_pend = 1'b0;
   logic [15:0]   m_half = '0;
   logic [AW-1:0] m_addr = '0;

   always #4 clk = ~clk;

   rvc_realigner #(.ADDR_W(AW)) u0 (
      .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .blk_valid_i(blk_valid_i),
      .blk_addr_i(blk_addr_i), .blk_data_i(blk_data_i), .slot_valid_o(slot_valid_o),
      .slot0_instr_o(slot0_instr_o), .slot1_instr_o(slot1_instr_o),
      .slot0_addr_o(slot0_addr_o), .slot1_addr_o(slot1_addr_o), .straddle_o(straddle_o)
   );

   function automatic bit is16(input logic [15:0] h);
      return h[1:0] != 2'b11;
   endfunction

   function automatic logic [15:0] rand_half();
      logic [15:0] h;
      h = 16'($urandom);
      if ($urandom_range(1, 0) == 1) h[1:0] = 2'b11;
      else h[1:0] = 2'($urandom_range(2, 0));
      return h;
   endfunction

   task automatic step(input logic v, input logic [AW-1:0] a, input logic [31:0] d,
                       input logic f, input string tag_in);
      logic [1:0]    ev;
      logic [31:0]   e0, e1;
      logic [AW-1:0] ea0, ea1, base, up;
      logic          est, np;
      logic [15:0]   lo, hi;
      string         tag;
      ev = 0; e0 = 0; e1 = 0; ea0 = 0; ea1 = 0; est = 0; np = 0;
      base = {a[AW-1:2], 2'b00};
      up = {a[AW-1:2], 2'b10};
      lo = d[15:0];
      hi = d[31:16];
      if (f) tag = "R9";
      else if (!v) tag = "R10";
      else if (m_pend) tag = is16(hi) ? "R7" : "R6";
      else if (a[1]) tag = "R8";
      else if (!is16(lo)) tag = "R3";
      else tag = is16(hi) ? "R4" : "R5";
      if (tag_in != "") tag = tag_in;
      if (v && !f) begin
         if (m_pend) begin
            ev[0] = 1; e0 = {lo, m_half}; ea0 = m_addr; est = 1;
            if (is16(hi)) begin ev[1] = 1; e1 = {16'h0, hi}; ea1 = up; end
            else np = 1;
         end else if (a[1]) begin
            if (is16(hi)) begin ev[0] = 1; e0 = {16'h0, hi}; ea0 = up; end
            else np = 1;
         end else if (!is16(lo)) begin
            ev[0] = 1; e0 = d; ea0 = base;
         end else begin
            ev[0] = 1; e0 = {16'h0, lo}; ea0 = base;
            if (is16(hi)) begin ev[1] = 1; e1 = {16'h0, hi}; ea1 = up; end
            else np = 1;
         end
      end
      @(negedge clk);
      blk_valid_i = v; blk_addr_i = a; blk_data_i = d; flush_i = f;
      #1;
      total++;
      if (slot_valid_o !== ev || straddle_o !== est ||
          (ev[0] && (slot0_instr_o !== e0 || slot0_addr_o !== ea0)) ||
          (ev[1] && (slot1_instr_o !== e1 || slot1_addr_o !== ea1))) begin
         bad++;
         $display("FAIL %s: got v=%b st=%b i0=%h a0=%h i1=%h a1=%h exp v=%b st=%b i0=%h a0=%h i1=%h a1=%h",
                  tag, slot_valid_o, straddle_o, slot0_instr_o, slot0_addr_o, slot1_instr_o,
                  slot1_addr_o, ev, est, e0, ea0, e1, ea1);
      end
      if (f) m_pend = 0;
      else if (v) begin
         m_pend = np;
         if (np) begin m_half = hi; m_addr = up; end
      end
   endtask

   initial begin
      #1_000_000;
      if (!finished) begin
         bad++; total++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [AW-1:0] pc;
      process::self().srandom(32'd20240611);
      repeat (3) @(negedge clk);
      total++;
      if (slot_valid_o !== 2'b00 || straddle_o !== 1'b0) begin
         bad++;
         $display("FAIL R1: reset outputs v=%b st=%b expected v=00 st=0", slot_valid_o, straddle_o);
      end
      rst_n = 1'b1;
      // directed corner cases
      step(1, 32'h100, 32'h0000_0013, 0, "R1");
      step(1, 32'h104, 32'h00A0_0093, 0, "R3");
      step(1, 32'h108, 32'h4505_4501, 0, "R4");
      step(1, 32'h10C, 32'h0513_8082, 0, "R5");
      step(0, 32'h110, 32'hFFFF_FFFF, 0, "R10");
      step(1, 32'h110, 32'h0793_00FF, 0, "R6");
      step(1, 32'h114, 32'h4501_0040, 0, "R7");
      step(1, 32'h118, 32'h4A73_4A70, 0, "R2");
      step(1, 32'h11C, 32'h0593_4A72, 0, "R5");
      step(1, 32'h120, 32'hFFFF_FFFF, 1, "R9");
      step(1, 32'h202, 32'h8082_0593, 0, "R8");
      step(1, 32'h206, 32'h0613_1111, 0, "R8");
      step(1, 32'h208, 32'h4501_0000, 0, "R6");
      // random traffic
      pc = 32'h1000;
      for (int i = 0; i < 4000; i++) begin
         logic v, f;
         v = $urandom_range(3, 0) != 0;
         f = $urandom_range(15, 0) == 0;
         step(v, pc, {rand_half(), rand_half()}, f, "");
         if (f) pc = {16'h0, 16'($urandom)} & 32'hFFFF_FFFE;
         else if (v) pc = {pc[AW-1:2] + 1'b1, 2'b00};
      end
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule